// File: doc/BRIEF.md
# Execute-Stage Operand and Destination Control

This block is the control decoder for the execute stage of a five-stage RISC pipeline. Its inputs are the instruction words held in the execute, memory and write-back stages, plus a 5-bit shift amount. It drives only select and code lines to the datapath around it. These are the 6-bit ALU operation, the shifter amount, the choice between ALU and shifter result, the operand mux selects with forwarding, the destination-register select and the branch-comparator selects. The ALU, shifter, register file and memories sit outside the block.

Forwarding looks at the destination register of the memory-stage instruction and the write-back-stage instruction. A memory-stage match takes the value from the data-address register. A write-back match takes the write-back mux output. If neither matches, the register-file read is used. The destination select picks which 5-bit register specifier travels down the pipe. The choices are the target field, the destination field, register 31 for link instructions, or a held copy kept in a flip-flop. The held copy is used for instructions that write no register.

Encoding used throughout: the opcode is bits [31:26] and the R-type function code is bits [5:0]. Source register rs is [25:21], rt is [20:16] and rd is [15:11]. Opcodes: 0x00 R-type, 0x02 J, 0x03 JAL, 0x04 BEQZ, 0x08 ADDI, 0x0A SLTI, 0x0C ANDI, 0x0D ORI, 0x0E XORI, 0x12 JR, 0x13 JALR, 0x23 load, 0x2B store. A register-writing instruction is one of these: any R-type (writes rd), ADDI/SLTI/ANDI/ORI/XORI/load (write rt), or JAL/JALR (write register 31).

Top module: `exctl_top`

## Requirements
- R1: aluOp equals the function code for R-type. It is 0x24 for ANDI, 0x25 for ORI, 0x26 for XORI and 0x2A for SLTI. Every other opcode gives 0x20 (add).
- R2: For R-type function codes 0x04, 0x06 and 0x07, useShifter is 1 and shiftOut equals shiftAmt. For every other instruction, useShifter is 0 and shiftOut is 0.
- R3: srcSel is 3 (PC) for J, JAL and JALR. Otherwise it is the forwarding code for rs: 0 write-back, 1 register file, 2 memory-stage address register.
- R4: tgtSel is 2 (sign-extended immediate) for every nonzero opcode, loads and stores included. For R-type it is the forwarding code for rt: 0 write-back, 1 register file, 3 memory-stage address register.
- R5: destSel is 1 (rd) for R-type, 0 (rt) for the rt-writing I-types and 2 (register 31) for JAL/JALR. All other instructions give 3 (held).
- R6: A memory-stage destination match beats a write-back match. Register 0 never counts as a match.
- R7: A load in the memory stage is never forwarded from the memory stage. The write-back or register-file choice applies instead.
- R8: cmpASel and cmpBSel carry the forwarding codes for rs and rt (0 write-back, 1 register file, 2 memory stage) for every instruction, never PC or immediate.
- R9: cmpResSel equals destSel for the set-less-than forms (R-type 0x2A and SLTI), and 3 otherwise.
- R10: destSpec is rt, rd or 31 as destSel says. When destSel is 3, destSpec is the value of the last specifier resolved with destSel not 3, held in a flip-flop. Reset clears that flip-flop to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| instrEx | input | 32 | Instruction in the execute stage |
| instrMem | input | 32 | Instruction in the memory stage |
| instrWb | input | 32 | Instruction in the write-back stage |
| shiftAmt | input | 5 | Shift amount for shift instructions |
| aluOp | output | 6 | ALU operation code |
| shiftOut | output | 5 | Amount given to the shifter |
| useShifter | output | 1 | 1 selects the shifter result, 0 the ALU |
| srcSel | output | 2 | Source operand mux select |
| tgtSel | output | 2 | Target operand mux select |
| destSel | output | 2 | Destination specifier mux select |
| destSpec | output | 5 | Resolved destination register specifier |
| cmpASel | output | 2 | Comparator first operand select |
| cmpBSel | output | 2 | Comparator second operand select |
| cmpResSel | output | 2 | Comparator result destination select |

## Verification
The assertions watch, on every cycle, the properties that hold between ports without a model. These are: no memory-stage forwarding for register 0 or for a load in the memory stage, the immediate on every non-R-type, a silent shifter when it is unused, register 31 for JAL, and a destination that stays put while held. Only the bench's sweep can show that each forwarding code is the right one. It covers every register overlap among three stages over a small register set, with memory-stage priority, write-back loads and non-writing producers. The sweep also shows the exact ALU codes per opcode and that the held specifier tracks the last writing instruction over long runs.

// File: rtl/exctl_pkg.sv
package exctl_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned OP_W   = 6;
  localparam int unsigned SEL_W  = 2;
  localparam logic [REG_W-1:0] LINK_REG = 5'd31;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OP_J     = 6'h02;
  localparam logic [OP_W-1:0] OP_JAL   = 6'h03;
  localparam logic [OP_W-1:0] OP_ADDI  = 6'h08;
  localparam logic [OP_W-1:0] OP_SLTI  = 6'h0A;
  localparam logic [OP_W-1:0] OP_ANDI  = 6'h0C;
  localparam logic [OP_W-1:0] OP_ORI   = 6'h0D;
  localparam logic [OP_W-1:0] OP_XORI  = 6'h0E;
  localparam logic [OP_W-1:0] OP_JALR  = 6'h13;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;

  localparam logic [OP_W-1:0] FN_SLL = 6'h04;
  localparam logic [OP_W-1:0] FN_SRL = 6'h06;
  localparam logic [OP_W-1:0] FN_SRA = 6'h07;
  localparam logic [OP_W-1:0] FN_ADD = 6'h20;
  localparam logic [OP_W-1:0] FN_AND = 6'h24;
  localparam logic [OP_W-1:0] FN_OR  = 6'h25;
  localparam logic [OP_W-1:0] FN_XOR = 6'h26;
  localparam logic [OP_W-1:0] FN_SLT = 6'h2A;

  // forwarding codes shared by the source and comparator muxes
  localparam logic [SEL_W-1:0] FWD_WB  = 2'd0;
  localparam logic [SEL_W-1:0] FWD_RF  = 2'd1;
  localparam logic [SEL_W-1:0] FWD_MEM = 2'd2;
  localparam logic [SEL_W-1:0] SRC_PC  = 2'd3;
  localparam logic [SEL_W-1:0] TGT_IMM = 2'd2;
  localparam logic [SEL_W-1:0] TGT_MEM = 2'd3;

  typedef enum logic [SEL_W-1:0] {
    DST_RT = 2'd0, DST_RD = 2'd1, DST_LINK = 2'd2, DST_HOLD = 2'd3
  } destSel_e;

  typedef struct packed {
    logic [OP_W-1:0] aluOp;
    logic            useShifter;
    logic            srcFromPc;
    logic            tgtFromImm;
    destSel_e        destSel;
    logic            isSet;
  } exCtl_t;

  function automatic logic writesRt(input logic [OP_W-1:0] op);
    return op inside {OP_ADDI, OP_SLTI, OP_ANDI, OP_ORI, OP_XORI, OP_LOAD};
  endfunction

  // register a producer writes, 0 when none (or a load, if excluded)
  function automatic logic [REG_W-1:0] producerDest(input logic [WORD_W-1:0] ins,
                                                    input logic allowLoad);
    logic [OP_W-1:0] op;
    op = ins[31:26];
    if (op == OP_RTYPE)                 return ins[15:11];
    if (op == OP_JAL || op == OP_JALR)  return LINK_REG;
    if (op == OP_LOAD && !allowLoad)    return '0;
    if (writesRt(op))                   return ins[20:16];
    return '0;
  endfunction
endpackage

// File: rtl/exctl_decode.sv
module exctl_decode
  import exctl_pkg::*;
(
  input  logic [WORD_W-1:0] instrEx,
  output exCtl_t            ctl
);
  logic [OP_W-1:0] opcode;
  logic [OP_W-1:0] funct;

  assign opcode = instrEx[31:26];
  assign funct  = instrEx[5:0];

  always_comb begin
    ctl            = '0;
    ctl.aluOp      = FN_ADD;
    ctl.tgtFromImm = 1'b1;
    ctl.destSel    = DST_HOLD;
    case (opcode)
      OP_RTYPE: begin
        ctl.aluOp      = funct;
        ctl.tgtFromImm = 1'b0;
        ctl.destSel    = DST_RD;
        ctl.useShifter = funct inside {FN_SLL, FN_SRL, FN_SRA};
        ctl.isSet      = (funct == FN_SLT);
      end
      OP_ADDI: ctl.destSel = DST_RT;
      OP_ANDI: begin ctl.aluOp = FN_AND; ctl.destSel = DST_RT; end
      OP_ORI:  begin ctl.aluOp = FN_OR;  ctl.destSel = DST_RT; end
      OP_XORI: begin ctl.aluOp = FN_XOR; ctl.destSel = DST_RT; end
      OP_SLTI: begin ctl.aluOp = FN_SLT; ctl.destSel = DST_RT; ctl.isSet = 1'b1; end
      OP_LOAD: ctl.destSel = DST_RT;
      OP_J:    ctl.srcFromPc = 1'b1;
      OP_JAL, OP_JALR: begin
        ctl.srcFromPc = 1'b1;
        ctl.destSel   = DST_LINK;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exctl_forward.sv
module exctl_forward
  import exctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  exCtl_t            ctl,
  input  logic [WORD_W-1:0] instrEx,
  input  logic [WORD_W-1:0] instrMem,
  input  logic [WORD_W-1:0] instrWb,
  input  logic [REG_W-1:0]  shiftAmt,
  output logic [REG_W-1:0]  shiftOut,
  output logic [SEL_W-1:0]  srcSel,
  output logic [SEL_W-1:0]  tgtSel,
  output logic [REG_W-1:0]  destSpec,
  output logic [SEL_W-1:0]  cmpASel,
  output logic [SEL_W-1:0]  cmpBSel,
  output logic [SEL_W-1:0]  cmpResSel
);
  localparam int unsigned N_OPND = 2;

  logic [REG_W-1:0] memDest, wbDest, heldDest, resolved;
  logic [REG_W-1:0] opndReg [N_OPND];
  logic [SEL_W-1:0] opndFwd [N_OPND];

  assign memDest    = producerDest(instrMem, 1'b0);
  assign wbDest     = producerDest(instrWb, 1'b1);
  assign opndReg[0] = instrEx[25:21];
  assign opndReg[1] = instrEx[20:16];

  for (genvar i = 0; i < N_OPND; i++) begin : g_fwd
    always_comb begin
      if (opndReg[i] != '0 && opndReg[i] == memDest)     opndFwd[i] = FWD_MEM;
      else if (opndReg[i] != '0 && opndReg[i] == wbDest) opndFwd[i] = FWD_WB;
      else                                               opndFwd[i] = FWD_RF;
    end
  end

  assign srcSel    = ctl.srcFromPc  ? SRC_PC  : opndFwd[0];
  assign tgtSel    = ctl.tgtFromImm ? TGT_IMM :
                     (opndFwd[1] == FWD_MEM ? TGT_MEM : opndFwd[1]);
  assign cmpASel   = opndFwd[0];
  assign cmpBSel   = opndFwd[1];
  assign cmpResSel = ctl.isSet ? ctl.destSel : DST_HOLD;
  assign shiftOut  = ctl.useShifter ? shiftAmt : '0;

  always_comb begin
    case (ctl.destSel)
      DST_RT:   resolved = instrEx[20:16];
      DST_RD:   resolved = instrEx[15:11];
      DST_LINK: resolved = LINK_REG;
      default:  resolved = heldDest;
    endcase
  end
  assign destSpec = resolved;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       heldDest <= '0;
    else if (ctl.destSel != DST_HOLD) heldDest <= resolved;
  end
endmodule

// File: rtl/exctl_top.sv
module exctl_top
  import exctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] instrEx,
  input  logic [31:0] instrMem,
  input  logic [31:0] instrWb,
  input  logic [4:0]  shiftAmt,
  output logic [5:0]  aluOp,
  output logic [4:0]  shiftOut,
  output logic        useShifter,
  output logic [1:0]  srcSel,
  output logic [1:0]  tgtSel,
  output logic [1:0]  destSel,
  output logic [4:0]  destSpec,
  output logic [1:0]  cmpASel,
  output logic [1:0]  cmpBSel,
  output logic [1:0]  cmpResSel
);
  exCtl_t ctl;

  exctl_decode u_dec (.instrEx(instrEx), .ctl(ctl));

  exctl_forward u_fwd (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .instrEx(instrEx), .instrMem(instrMem), .instrWb(instrWb),
    .shiftAmt(shiftAmt), .shiftOut(shiftOut),
    .srcSel(srcSel), .tgtSel(tgtSel), .destSpec(destSpec),
    .cmpASel(cmpASel), .cmpBSel(cmpBSel), .cmpResSel(cmpResSel)
  );

  assign aluOp      = ctl.aluOp;
  assign useShifter = ctl.useShifter;
  assign destSel    = ctl.destSel;
endmodule

// File: rtl/exctl_checker.sv
module exctl_checker (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] instrEx,
  input logic [31:0] instrMem,
  input logic [4:0]  shiftOut,
  input logic        useShifter,
  input logic [1:0]  srcSel,
  input logic [1:0]  tgtSel,
  input logic [1:0]  destSel,
  input logic [4:0]  destSpec
);
  // R6: a memory-stage source pick never names register 0
  assert_mem_nonzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel == 2'd2) |-> (instrEx[25:21] != 5'd0));

  // R7: a load in the memory stage is not a forwarding source
  assert_no_load_fwd_R7: assert property (@(posedge clk) disable iff (!rstN)
    (instrMem[31:26] == 6'h23) |-> (srcSel != 2'd2 && tgtSel != 2'd3));

  // R4: every non-R-type takes the immediate as target
  assert_imm_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    (instrEx[31:26] != 6'h00) |-> (tgtSel == 2'd2));

  // R2: shifter amount is zero when the shifter is unused
  assert_shift_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !useShifter |-> (shiftOut == 5'd0));

  // R5: JAL routes to register 31
  assert_link_dest_R5: assert property (@(posedge clk) disable iff (!rstN)
    (instrEx[31:26] == 6'h03) |-> (destSel == 2'd2 && destSpec == 5'd31));

  // R10: entering the held choice keeps the previous specifier
  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (destSel != 2'd3) ##1 (destSel == 2'd3) |-> (destSpec == $past(destSpec)));
endmodule

bind exctl_top exctl_checker u_chk (
  .clk(clk), .rstN(rstN), .instrEx(instrEx), .instrMem(instrMem),
  .shiftOut(shiftOut), .useShifter(useShifter), .srcSel(srcSel),
  .tgtSel(tgtSel), .destSel(destSel), .destSpec(destSpec)
);

// File: tb/sim_exctl_top.sv
`timescale 1ns/1ps
module sim_exctl_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instrEx = '0, instrMem = '0, instrWb = '0;
  logic [4:0]  shiftAmt = '0;
  logic [5:0]  aluOp;
  logic [4:0]  shiftOut, destSpec;
  logic        useShifter;
  logic [1:0]  srcSel, tgtSel, destSel, cmpASel, cmpBSel, cmpResSel;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  exctl_top u0 (.*);

  task automatic chk(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (kind case at %0t)", req, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] rIns(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd9, fn};
  endfunction
  function automatic logic [31:0] iIns(input logic [5:0] op, input int rs, input int rt);
    return {op, 5'(rs), 5'(rt), 16'hA5C3};
  endfunction

  // expected forwarding code for one operand register
  function automatic int fwdCode(input int r, input int memD, input int wbD);
    if (r != 0 && r == memD) return 2;
    if (r != 0 && r == wbD)  return 0;
    return 1;
  endfunction

  initial begin
    int modelHeld;
    instrEx = iIns(6'h02, 0, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 reset held", destSpec, 0);
    chk("R5 reset J dest", destSel, 3);
    chk("R1 reset J alu", aluOp, 'h20);
    rstN = 1'b1;
    modelHeld = 0;
    for (int kind = 0; kind < 16; kind++)
    for (int rs = 0; rs < 4; rs++)
    for (int rt = 0; rt < 4; rt++)
    for (int mk = 0; mk < 3; mk++)
    for (int md = 0; md < 4; md++)
    for (int wk = 0; wk < 3; wk++)
    for (int wd = 0; wd < 4; wd++) begin
      int rd, memD, wbD, fs, ft, eAlu, eShf, eSrc, eTgt, eDst, eSpec, eRes;
      bit isSet;
      rd = (rs + 2 * rt + 1) % 4;
      @(negedge clk);
      shiftAmt = 5'((kind * 7 + rs + md + wd * 3) % 32);
      case (mk)
        0: instrMem = rIns(0, 0, md, 6'h20);
        1: instrMem = iIns(6'h23, 0, md);
        default: instrMem = iIns(6'h2B, 0, md);
      endcase
      case (wk)
        0: instrWb = iIns(6'h08, 0, wd);
        1: instrWb = iIns(6'h23, 0, wd);
        default: instrWb = iIns(6'h04, wd, 0);
      endcase
      eAlu = 'h20; eShf = 0; eSrc = -1; eTgt = -1; eDst = 3; isSet = 0;
      case (kind)
        0:  begin instrEx = rIns(rs, rt, rd, 6'h20); eDst = 1; end
        1:  begin instrEx = rIns(rs, rt, rd, 6'h22); eDst = 1; eAlu = 'h22; end
        2:  begin instrEx = rIns(rs, rt, rd, 6'h2A); eDst = 1; eAlu = 'h2A; isSet = 1; end
        3:  begin instrEx = rIns(rs, rt, rd, 6'h04); eDst = 1; eAlu = 'h04; eShf = 1; end
        4:  begin instrEx = rIns(rs, rt, rd, 6'h07); eDst = 1; eAlu = 'h07; eShf = 1; end
        5:  begin instrEx = iIns(6'h08, rs, rt); eDst = 0; end
        6:  begin instrEx = iIns(6'h0A, rs, rt); eDst = 0; eAlu = 'h2A; isSet = 1; end
        7:  begin instrEx = iIns(6'h0D, rs, rt); eDst = 0; eAlu = 'h25; end
        8:  begin instrEx = iIns(6'h23, rs, rt); eDst = 0; end
        9:  instrEx = iIns(6'h2B, rs, rt);
        10: instrEx = iIns(6'h04, rs, rt);
        11: begin instrEx = iIns(6'h02, rs, rt); eSrc = 3; end
        12: begin instrEx = iIns(6'h03, rs, rt); eSrc = 3; eDst = 2; end
        13: begin instrEx = iIns(6'h13, rs, rt); eSrc = 3; eDst = 2; end
        14: instrEx = iIns(6'h12, rs, rt);
        default: instrEx = iIns(6'h3F, rs, rt);
      endcase
      memD = (mk == 0) ? md : 0;     // R7: loads and stores give no memory-stage match
      wbD  = (wk < 2) ? wd : 0;
      fs = fwdCode(rs, memD, wbD);
      ft = fwdCode(rt, memD, wbD);
      if (eSrc < 0) eSrc = fs;
      if (kind <= 4) eTgt = (ft == 2) ? 3 : ft; else eTgt = 2;
      case (eDst)
        0: eSpec = rt;
        1: eSpec = rd;
        2: eSpec = 31;
        default: eSpec = modelHeld;
      endcase
      eRes = isSet ? eDst : 3;
      #1;
      chk("R1 aluOp", aluOp, eAlu);
      chk("R2 useShifter", useShifter, eShf);
      chk("R2 shiftOut", shiftOut, eShf ? int'(shiftAmt) : 0);
      chk("R3 R6 R7 srcSel", srcSel, eSrc);
      chk("R4 R6 R7 tgtSel", tgtSel, eTgt);
      chk("R5 destSel", destSel, eDst);
      chk("R8 cmpASel", cmpASel, fs);
      chk("R8 cmpBSel", cmpBSel, ft);
      chk("R9 cmpResSel", cmpResSel, eRes);
      chk("R10 destSpec", destSpec, eSpec);
      if (eDst != 3) modelHeld = eSpec;
    end
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule